// File: doc/BRIEF.md
# Shared-Buffer Cell Switch

This block is an N-port cell switch in which all output queues share one central pool of cell buffers. Time is divided into cell times of 2N clock cycles. In the first N cycles of a cell time, each input in turn gets a single cycle to hand over one cell. The controller looks up the cell's virtual-path field in a route table, takes one free buffer for every destination, writes a copy of the cell into each of those buffers, and links each copy onto the tail of that output's queue. In the last N cycles, each output in turn gets a single cycle to move the cell at the head of its queue into its output holding register. That buffer then goes back to the free pool.

The cell interfaces use valid/ready handshakes. An input is accepted only in its own write cycle, so a sender holds `in_valid` and its data until it sees `in_ready`. An accepted cell is never refused afterwards. If it cannot be stored, it is discarded and the discard is reported. On the output side, a cell stays presented until the consumer raises `out_ready`. While the holding register is full, the cell waiting in the queue stays in shared memory. The route table is written through a plain configuration port. Each table entry is a valid flag and a destination bitmask, where bit k selects output k.

Top module: `sms_cell_switch`

## Requirements
- R1: After reset the block counts cycles 0..2N-1 of each cell time, starting at 0. `in_ready[i]` is high only in cycle i, and no input is ready in cycles N..2N-1.
- R2: The route key is bits [CELL_W-1 -: VPI_W] of the cell. An accepted cell whose entry is valid with a non-zero mask is delivered unchanged on every output whose mask bit is set.
- R3: A cell whose mask has several bits set is copied into each of those outputs' queues, and every copy is delivered.
- R4: Each output delivers its cells in the order of their acceptance.
- R5: An accepted cell whose entry is invalid, or whose mask is zero, is discarded. `lookup_err[i]` pulses high for one cycle in the cycle after input i's handshake.
- R6: If the free buffers are fewer than the destinations of a routable cell, the whole cell is discarded and `drop_cnt` slice i (input i) increments by one.
- R7: While `out_valid[o]` is high and `out_ready[o]` is low, `out_valid[o]` stays high and `out_data` slice o stays unchanged.
- R8: A buffer returns to the pool when its cell moves to the output holding register, so the pool never loses or gains buffers. The queued copies plus the free buffers always equal BUF_DEPTH.
- R9: A table write with `cfg_we` high applies to cells accepted from the next cycle onward.
- R10: Reset clears all outputs, error pulses and drop counters, and marks every table entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Per-input cell present |
| in_ready | output | N_PORTS | Per-input accept strobe (own write cycle) |
| in_data | input | N_PORTS*CELL_W | Input cells, input i in slice i |
| out_valid | output | N_PORTS | Per-output cell present |
| out_ready | input | N_PORTS | Per-output consumer ready |
| out_data | output | N_PORTS*CELL_W | Output cells, output o in slice o |
| lookup_err | output | N_PORTS | Per-input route-miss pulse |
| drop_cnt | output | N_PORTS*DROP_W | Per-input count of cells discarded for lack of buffers |
| cfg_we | input | 1 | Route table write enable |
| cfg_vpi | input | VPI_W | Route table entry to write |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_mask | input | N_PORTS | Destination mask to store |

## Verification
Several internal faults would show up at the outputs:
- A broken link or head pointer shows up within one cell time as a cell delivered out of order, or a cell repeated or missing on the affected output. The scoreboard catches this on the next handshake.
- A pool that leaks buffers shows up only under load, as drops appearing earlier than the buffer count allows. A full-fill test therefore compares the exact drop count with the arithmetic limit, then refills the pool to prove the buffers came back.
- A wrong slot decoder shows up within the first cell time after reset, in the `in_ready` pattern.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic {PH_WRITE = 1'b0, PH_READ = 1'b1} phase_e;
endpackage

// File: rtl/sms_slot_timer.sv
module sms_slot_timer #(
  parameter int N_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output sms_pkg::phase_e      phase,
  output logic [$clog2(N_PORTS)-1:0] port_sel
);
  localparam int SUB_W  = $clog2(2 * N_PORTS);
  localparam int PORT_W = $clog2(N_PORTS);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(2 * N_PORTS - 1);
  localparam logic [SUB_W-1:0] HALF = SUB_W'(N_PORTS);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            sub_q <= '0;
    else if (sub_q == LAST) sub_q <= '0;
    else                   sub_q <= sub_q + 1'b1;
  end

  always_comb begin
    if (sub_q < HALF) begin
      phase    = sms_pkg::PH_WRITE;
      port_sel = PORT_W'(sub_q);
    end else begin
      phase    = sms_pkg::PH_READ;
      port_sel = PORT_W'(sub_q - HALF);
    end
  end
endmodule

// File: rtl/sms_vp_table.sv
module sms_vp_table #(
  parameter int N_PORTS = 4,
  parameter int VPI_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VPI_W-1:0]   wr_key,
  input  logic               wr_valid,
  input  logic [N_PORTS-1:0] wr_mask,
  input  logic [VPI_W-1:0]   rd_key,
  output logic               rd_valid,
  output logic [N_PORTS-1:0] rd_mask
);
  localparam int ENTRIES = 1 << VPI_W;

  logic [ENTRIES-1:0]              vld_q;
  logic [N_PORTS-1:0] mask_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)      vld_q <= '0;
    else if (wr_en)  vld_q[wr_key] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mask_q[wr_key] <= wr_mask;
  end

  assign rd_valid = vld_q[rd_key];
  assign rd_mask  = mask_q[rd_key];
endmodule

// File: rtl/sms_buf_pool.sv
module sms_buf_pool #(
  parameter int N_PORTS   = 4,
  parameter int BUF_DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_en,
  input  logic [N_PORTS-1:0] want,
  input  logic rel_en,
  input  logic [$clog2(BUF_DEPTH)-1:0] rel_idx,
  output logic [N_PORTS-1:0][$clog2(BUF_DEPTH)-1:0] grant,
  output logic room,
  output logic [$clog2(BUF_DEPTH+1)-1:0] free_cnt
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [BUF_DEPTH-1:0] free_q, avail, free_d;
  logic [CNT_W-1:0]     need;

  // Chain of priority picks: output o takes the lowest buffer left after outputs below it.
  always_comb begin
    avail = free_q;
    need  = '0;
    for (int o = 0; o < N_PORTS; o++) begin
      logic found;
      found    = 1'b0;
      grant[o] = '0;
      if (want[o]) begin
        need = need + 1'b1;
        for (int b = 0; b < BUF_DEPTH; b++) begin
          if (!found && avail[b]) begin
            grant[o] = IDX_W'(b);
            avail[b] = 1'b0;
            found    = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int b = 0; b < BUF_DEPTH; b++) free_cnt = free_cnt + CNT_W'(free_q[b]);
  end

  assign room = (free_cnt >= need);

  always_comb begin
    free_d = free_q;
    if (alloc_en && room) free_d = avail;
    if (rel_en) free_d[rel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end
endmodule

// File: rtl/sms_cell_switch.sv
module sms_cell_switch #(
  parameter int N_PORTS   = 4,
  parameter int CELL_W    = 32,
  parameter int VPI_W     = 8,
  parameter int BUF_DEPTH = 16,
  parameter int DROP_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          in_valid,
  output logic [N_PORTS-1:0]          in_ready,
  input  logic [N_PORTS*CELL_W-1:0]   in_data,
  output logic [N_PORTS-1:0]          out_valid,
  input  logic [N_PORTS-1:0]          out_ready,
  output logic [N_PORTS*CELL_W-1:0]   out_data,
  output logic [N_PORTS-1:0]          lookup_err,
  output logic [N_PORTS*DROP_W-1:0]   drop_cnt,
  input  logic                        cfg_we,
  input  logic [VPI_W-1:0]            cfg_vpi,
  input  logic                        cfg_valid,
  input  logic [N_PORTS-1:0]          cfg_mask
);
  localparam int PORT_W = $clog2(N_PORTS);
  localparam int IDX_W  = $clog2(BUF_DEPTH);
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);

  sms_pkg::phase_e   phase;
  logic [PORT_W-1:0] port_sel;

  sms_slot_timer #(.N_PORTS(N_PORTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .port_sel(port_sel)
  );

  // ---------------- write side ----------------
  logic [CELL_W-1:0]  cell_in;
  logic               accept, route_vld, hit, commit, room;
  logic [N_PORTS-1:0] dest;
  logic [N_PORTS-1:0][IDX_W-1:0] grant;
  logic [CNT_W-1:0]   free_cnt;

  assign cell_in = in_data[int'(port_sel)*CELL_W +: CELL_W];
  assign accept  = (phase == sms_pkg::PH_WRITE) && in_valid[port_sel];

  always_comb begin
    for (int i = 0; i < N_PORTS; i++)
      in_ready[i] = (phase == sms_pkg::PH_WRITE) && (port_sel == PORT_W'(i));
  end

  sms_vp_table #(.N_PORTS(N_PORTS), .VPI_W(VPI_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_key(cfg_vpi), .wr_valid(cfg_valid), .wr_mask(cfg_mask),
    .rd_key(cell_in[CELL_W-1 -: VPI_W]), .rd_valid(route_vld), .rd_mask(dest)
  );

  assign hit    = route_vld && (|dest);
  assign commit = accept && hit && room;

  // ---------------- read side ----------------
  logic [N_PORTS-1:0][IDX_W-1:0] head_q, tail_q;
  logic [N_PORTS-1:0][CNT_W-1:0] qcnt_q;
  logic              load;
  logic [IDX_W-1:0]  rd_idx;

  assign rd_idx = head_q[port_sel];
  assign load   = (phase == sms_pkg::PH_READ) && !out_valid[port_sel]
                  && (qcnt_q[port_sel] != '0);

  sms_buf_pool #(.N_PORTS(N_PORTS), .BUF_DEPTH(BUF_DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept && hit), .want(hit ? dest : '0),
    .rel_en(load), .rel_idx(rd_idx),
    .grant(grant), .room(room), .free_cnt(free_cnt)
  );

  // Shared cell storage and link array.
  logic [CELL_W-1:0] mem_q [BUF_DEPTH];
  logic [IDX_W-1:0]  nxt_q [BUF_DEPTH];

  always_ff @(posedge clk) begin
    for (int o = 0; o < N_PORTS; o++) begin
      if (commit && dest[o]) begin
        mem_q[grant[o]] <= cell_in;
        if (qcnt_q[o] != '0) nxt_q[tail_q[o]] <= grant[o];
      end
    end
  end

  // Queue pointers: enqueue in write cycles, dequeue in read cycles.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      qcnt_q <= '0;
    end else begin
      for (int o = 0; o < N_PORTS; o++) begin
        if (commit && dest[o]) begin
          if (qcnt_q[o] == '0) head_q[o] <= grant[o];
          tail_q[o] <= grant[o];
          qcnt_q[o] <= qcnt_q[o] + 1'b1;
        end
      end
      if (load) begin
        head_q[port_sel] <= nxt_q[rd_idx];
        qcnt_q[port_sel] <= qcnt_q[port_sel] - 1'b1;
      end
    end
  end

  // Output holding registers.
  logic [N_PORTS-1:0][CELL_W-1:0] odata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
    end else begin
      for (int o = 0; o < N_PORTS; o++) begin
        if (out_valid[o] && out_ready[o]) out_valid[o] <= 1'b0;
        if (load && port_sel == PORT_W'(o)) out_valid[o] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) odata_q <= '0;
    else if (load) odata_q[port_sel] <= mem_q[rd_idx];
  end

  assign out_data = odata_q;

  // Route-miss pulses and per-input discard counters.
  logic [N_PORTS-1:0][DROP_W-1:0] drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lookup_err <= '0;
      drop_q     <= '0;
    end else begin
      lookup_err <= '0;
      if (accept && !hit) lookup_err[port_sel] <= 1'b1;
      if (accept && hit && !room) drop_q[port_sel] <= drop_q[port_sel] + 1'b1;
    end
  end

  assign drop_cnt = drop_q;
endmodule

// File: rtl/sms_cell_switch_chk.sv
module sms_cell_switch_chk #(
  parameter int N_PORTS   = 4,
  parameter int CELL_W    = 32,
  parameter int BUF_DEPTH = 16,
  parameter int DROP_W    = 8,
  parameter int CNT_W     = 5
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [N_PORTS-1:0]                 in_valid,
  input logic [N_PORTS-1:0]                 in_ready,
  input logic [N_PORTS-1:0]                 out_valid,
  input logic [N_PORTS-1:0]                 out_ready,
  input logic [N_PORTS*CELL_W-1:0]          out_data,
  input logic [N_PORTS-1:0]                 lookup_err,
  input logic [N_PORTS*DROP_W-1:0]          drop_cnt,
  input logic [N_PORTS-1:0][CNT_W-1:0]      qcnt,
  input logic [CNT_W-1:0]                   free_cnt
);
  int held_total;
  always_comb begin
    held_total = int'(free_cnt);
    for (int o = 0; o < N_PORTS; o++) held_total = held_total + int'(qcnt[o]);
  end

  // R1: at most one input is offered a write cycle at a time
  assert_one_write_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R8: every buffer is either queued or free
  assert_buffer_conservation_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held_total == BUF_DEPTH);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // R7: a presented cell waits unchanged for its consumer
    assert_hold_until_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_ready[p]) |=>
        (out_valid[p] && $stable(out_data[p*CELL_W +: CELL_W])));

    // R5: an error pulse follows a handshake on the same input
    assert_err_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_err[p] |-> $past(in_valid[p] && in_ready[p]));

    // R6: a drop counter only ever steps by one
    assert_drop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt[p*DROP_W +: DROP_W]) |->
        (drop_cnt[p*DROP_W +: DROP_W] == $past(drop_cnt[p*DROP_W +: DROP_W]) + 1'b1));
  end
endmodule

bind sms_cell_switch sms_cell_switch_chk #(
  .N_PORTS(N_PORTS), .CELL_W(CELL_W), .BUF_DEPTH(BUF_DEPTH),
  .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .lookup_err(lookup_err), .drop_cnt(drop_cnt),
  .qcnt(qcnt_q), .free_cnt(free_cnt)
);

// File: tb/sms_cell_switch_tb.sv
`timescale 1ns/1ps
module sms_cell_switch_tb;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int VW = 8;
  localparam int D  = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]        in_valid = '0;
  logic [N-1:0]        in_ready;
  logic [N-1:0][W-1:0] in_data_b = '0;
  logic [N-1:0]        out_valid;
  logic [N-1:0]        out_ready = '0;
  logic [N*W-1:0]      out_data;
  logic [N-1:0]        lookup_err;
  logic [N*DW-1:0]     drop_cnt;
  logic                cfg_we = 1'b0;
  logic [VW-1:0]       cfg_vpi = '0;
  logic                cfg_valid = 1'b0;
  logic [N-1:0]        cfg_mask = '0;

  sms_cell_switch #(.N_PORTS(N), .CELL_W(W), .VPI_W(VW), .BUF_DEPTH(D), .DROP_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .lookup_err(lookup_err), .drop_cnt(drop_cnt),
    .cfg_we(cfg_we), .cfg_vpi(cfg_vpi), .cfg_valid(cfg_valid), .cfg_mask(cfg_mask)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  int err_seen [N];

  logic [W-1:0] exp_q [N][$];
  logic         tb_vld  [256];
  logic [N-1:0] tb_mask [256];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic bit all_empty();
    for (int o = 0; o < N; o++) if (exp_q[o].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < N; o++) begin
        if (lookup_err[o]) err_seen[o]++;
        if (out_valid[o] && out_ready[o]) begin
          if (exp_q[o].size() == 0) begin
            chk(1'b0, "R2 unexpected cell", 64'(out_data[o*W +: W]), 64'(0));
          end else begin
            logic [W-1:0] e;
            e = exp_q[o].pop_front();
            chk(out_data[o*W +: W] == e, "R2/R3/R4 routed cell", 64'(out_data[o*W +: W]), 64'(e));
          end
        end
      end
    end
  end

  task automatic cfg(logic [VW-1:0] key, logic v, logic [N-1:0] m);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_vpi = key; cfg_valid = v; cfg_mask = m;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    tb_vld[key] = v; tb_mask[key] = m;
  endtask

  // Driver: pushes expected copies at the handshake
  task automatic send(int p, logic [W-1:0] c, bit deliver);
    @(posedge clk); #1;
    in_valid[p] = 1'b1; in_data_b[p] = c;
    forever begin
      @(negedge clk);
      if (in_ready[p]) break;
    end
    @(posedge clk); #1;
    in_valid[p] = 1'b0;
    if (deliver && tb_vld[c[W-1 -: VW]] && (tb_mask[c[W-1 -: VW]] != '0))
      for (int o = 0; o < N; o++)
        if (tb_mask[c[W-1 -: VW]][o]) exp_q[o].push_back(c);
  endtask

  task automatic wait_drain(string req);
    for (int t = 0; t < 3000 && !all_empty(); t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(all_empty(), req, 64'(0), 64'(1));
  endtask

  task automatic set_ready(logic [N-1:0] r);
    @(posedge clk); #1;
    out_ready = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) begin tb_vld[k] = 1'b0; tb_mask[k] = '0; end
    for (int o = 0; o < N; o++) err_seen[o] = 0;

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state, R1 write-slot pattern
    for (int k = 0; k < 2 * N * 2; k++) begin
      logic [N-1:0] e;
      @(negedge clk);
      e = ((k % (2 * N)) < N) ? N'(1 << (k % (2 * N))) : '0;
      if (k == 0) begin
        chk(out_valid == '0, "R10 out_valid", 64'(out_valid), 64'(0));
        chk(drop_cnt == '0, "R10 drop_cnt", 64'(drop_cnt), 64'(0));
        chk(lookup_err == '0, "R10 lookup_err", 64'(lookup_err), 64'(0));
      end
      chk(in_ready == e, "R1 in_ready slot", 64'(in_ready), 64'(e));
    end

    out_ready = '1;
    // R10: table empty after reset, so this is a miss on input 0
    send(0, 32'h1100_0001, 1'b1);

    cfg(8'h10, 1'b1, 4'b0100);
    cfg(8'h20, 1'b1, 4'b0001);
    cfg(8'h30, 1'b1, 4'b1011);
    cfg(8'h40, 1'b1, 4'b0000);

    // R2 unicast from every input
    for (int i = 0; i < N; i++) send(i, {8'h10, 24'(16'hA000 + i)}, 1'b1);
    send(1, 32'h2000_0B01, 1'b1);
    wait_drain("R2 unicast drained");

    // R4 concurrent inputs into one output
    fork
      for (int k = 0; k < 3; k++) send(0, {8'h20, 24'(32'h0C00 + k)}, 1'b1);
      for (int k = 0; k < 3; k++) send(1, {8'h20, 24'(32'h0C10 + k)}, 1'b1);
      for (int k = 0; k < 3; k++) send(2, {8'h20, 24'(32'h0C20 + k)}, 1'b1);
      for (int k = 0; k < 3; k++) send(3, {8'h20, 24'(32'h0C30 + k)}, 1'b1);
    join
    wait_drain("R4 order drained");

    // R3 multicast to outputs 0,1,3
    send(3, 32'h3000_0D01, 1'b1);
    send(2, 32'h3000_0D02, 1'b1);
    wait_drain("R3 multicast drained");

    // R5 misses: zero mask on input 2, invalid entry on input 1
    send(2, 32'h4000_0E01, 1'b1);
    send(1, 32'h9900_0E02, 1'b1);
    repeat (4) @(negedge clk);
    chk(err_seen[0] == 1, "R5 err input 0", 64'(err_seen[0]), 64'(1));
    chk(err_seen[1] == 1, "R5 err input 1", 64'(err_seen[1]), 64'(1));
    chk(err_seen[2] == 1, "R5 err input 2", 64'(err_seen[2]), 64'(1));
    chk(err_seen[3] == 0, "R5 err input 3", 64'(err_seen[3]), 64'(0));
    wait_drain("R5 nothing delivered");

    // R9 reroute takes effect
    cfg(8'h10, 1'b1, 4'b1000);
    send(0, 32'h1000_0F01, 1'b1);
    wait_drain("R9 rerouted cell drained");

    // R7 back-pressure on output 1
    cfg(8'h50, 1'b1, 4'b0010);
    set_ready(4'b1101);
    send(0, 32'h5000_1234, 1'b1);
    repeat (20) @(negedge clk);
    chk(out_valid[1] == 1'b1, "R7 held valid", 64'(out_valid[1]), 64'(1));
    chk(out_data[1*W +: W] == 32'h5000_1234, "R7 held data", 64'(out_data[1*W +: W]), 64'h5000_1234);
    repeat (7) @(negedge clk);
    chk(out_data[1*W +: W] == 32'h5000_1234, "R7 data stable", 64'(out_data[1*W +: W]), 64'h5000_1234);
    set_ready('1);
    wait_drain("R7 released cell drained");

    // R6 pool exhaustion: 16 buffers plus one holding register on output 0
    set_ready(4'b1110);
    for (int k = 0; k < 20; k++) send(0, {8'h20, 24'(32'h2200 + k)}, k < 17);
    repeat (4) @(negedge clk);
    chk(drop_cnt[0 +: DW] == 8'd3, "R6 drops input 0", 64'(drop_cnt[0 +: DW]), 64'(3));
    chk(drop_cnt[DW +: 3*DW] == '0, "R6 other inputs", 64'(drop_cnt[DW +: 3*DW]), 64'(0));
    set_ready('1);
    wait_drain("R6 stored cells drained");

    // R8 all buffers returned: refill without drops
    set_ready(4'b1110);
    for (int k = 0; k < 17; k++) send(1, {8'h20, 24'(32'h3300 + k)}, 1'b1);
    repeat (4) @(negedge clk);
    chk(drop_cnt[DW +: DW] == '0, "R8 no drop after refill", 64'(drop_cnt[DW +: DW]), 64'(0));
    set_ready('1);
    wait_drain("R8 refill drained");
    chk(drop_cnt[0 +: DW] == 8'd3, "R6 count kept", 64'(drop_cnt[0 +: DW]), 64'(3));

    done = 1'b1;
    summary();
  end
endmodule